// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a chain of scan cells made from level-sensitive storage rather than edge-triggered flip-flops. Each cell holds a master latch and a slave latch. The master latch takes functional data while the capture clock is high, or takes serial test data while the master shift clock is high. The slave latch copies the master while the slave shift clock is high. The slave output of each cell feeds the serial input of the next cell. The slave output of the last cell is the serial output of the chain.

In normal operation both shift clocks stay low, and a pulse on the capture clock loads the parallel data into the masters. In test operation the capture clock stays low. Each master pulse followed by a slave pulse moves the chain contents one cell toward the serial output. The three clocks must never be high together. A monitor records every pair of clocks that has overlapped and keeps that record until reset.

Top module: `lvl_scan_chain`

## Requirements
- R1: While `rst` is high, every master latch, every slave latch, `ovl_any` and `ovl_seen` read 0.
- R2: While `cap_clk` is high, `mst_q` follows `par_in`. While it is low, changes on `par_in` leave `mst_q` unchanged.
- R3: While `shift_clk_m` is high and the other two clocks are low, master bit 0 follows `scan_in` and master bit i (i>0) follows slave bit i-1.
- R4: While `shift_clk_s` is high, `slv_q` follows `mst_q`. While it is low, `slv_q` holds, including across a master-only pulse.
- R5: `scan_out` equals slave bit WIDTH-1. After a capture and a slave transfer, WIDTH shift pairs present the captured word on `scan_out` with bit WIDTH-1 first.
- R6: Each complete master-then-slave pulse pair moves the chain exactly one position. After WIDTH pairs, the bit shifted in first sits in slave bit WIDTH-1.
- R7: When any two of the three clocks are high at once, `ovl_any` goes to 1. It stays at 1 after the clocks return low and through later legal pulses, until `rst`.
- R8: `ovl_seen` bit 0 marks capture with master-shift overlap, bit 1 marks capture with slave-shift overlap, and bit 2 marks master-shift with slave-shift overlap. Each bit is sticky on its own, so several bits can be set together.
- R9: When the capture clock and the master shift clock are both high, the master latches follow `par_in`.
- R10: While `rst` is high, a capture pulse does not load the master latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset, level acting; clears all latches and flags |
| cap_clk | input | 1 | Capture clock; master latches take `par_in` while high |
| shift_clk_m | input | 1 | Master shift clock; master latches take serial data while high |
| shift_clk_s | input | 1 | Slave shift clock; slave latches copy masters while high |
| par_in | input | WIDTH | Functional data, one bit per cell |
| scan_in | input | 1 | Serial test input to cell 0 |
| mst_q | output | WIDTH | Master latch contents |
| slv_q | output | WIDTH | Slave latch contents |
| scan_out | output | 1 | Slave output of the last cell |
| ovl_any | output | 1 | Sticky flag: some clock overlap has occurred |
| ovl_seen | output | 3 | Sticky per-pair overlap record |

## Verification
The latch-content properties are checked on the falling edge of the clock that closes the latch. They assume that `par_in` and `scan_in` do not change in the same instant as that edge. They also assume that `rst` starts high, so that no flag falls from an unknown value outside reset. The bench changes data and clocks only on rising edges of its own timing clock, at different instants. It holds reset from time zero. It builds every overlap by raising and lowering the clocks one at a time, so every falling clock edge sees settled latch values.

// File: rtl/lvl_scan_pkg.sv
package lvl_scan_pkg;
  localparam int unsigned OVL_CA = 0;
  localparam int unsigned OVL_CB = 1;
  localparam int unsigned OVL_AB = 2;
  localparam int unsigned OVL_N  = 3;

  typedef logic [OVL_N-1:0] ovl_vec_t;

  function automatic ovl_vec_t ovl_detect(input logic c, input logic m, input logic s);
    ovl_vec_t v;
    v         = '0;
    v[OVL_CA] = c & m;
    v[OVL_CB] = c & s;
    v[OVL_AB] = m & s;
    return v;
  endfunction
endpackage

// File: rtl/lvl_scan_cell.sv
module lvl_scan_cell (
  input  logic rst,
  input  logic cap_clk,
  input  logic shift_clk_m,
  input  logic shift_clk_s,
  input  logic d_in,
  input  logic s_in,
  output logic m_q,
  output logic s_q
);
  logic m_r;
  logic s_r;

  // master: capture takes priority over serial load
  always_latch begin
    if (rst)              m_r <= 1'b0;
    else if (cap_clk)     m_r <= d_in;
    else if (shift_clk_m) m_r <= s_in;
  end

  // slave: transparent to master while slave clock high
  always_latch begin
    if (rst)              s_r <= 1'b0;
    else if (shift_clk_s) s_r <= m_r;
  end

  assign m_q = m_r;
  assign s_q = s_r;
endmodule

// File: rtl/lvl_scan_overlap.sv
module lvl_scan_overlap
  import lvl_scan_pkg::*;
(
  input  logic     rst,
  input  logic     cap_clk,
  input  logic     shift_clk_m,
  input  logic     shift_clk_s,
  output ovl_vec_t seen,
  output logic     any
);
  ovl_vec_t now_v;

  always_comb now_v = ovl_detect(cap_clk, shift_clk_m, shift_clk_s);

  for (genvar k = 0; k < OVL_N; k++) begin : g_flag
    logic flag;
    always_latch begin
      if (rst)           flag <= 1'b0;
      else if (now_v[k]) flag <= 1'b1;
    end
    assign seen[k] = flag;
  end

  assign any = |seen;
endmodule

// File: rtl/lvl_scan_chain.sv
module lvl_scan_chain
  import lvl_scan_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             rst,
  input  logic             cap_clk,
  input  logic             shift_clk_m,
  input  logic             shift_clk_s,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] mst_q,
  output logic [WIDTH-1:0] slv_q,
  output logic             scan_out,
  output logic             ovl_any,
  output logic [OVL_N-1:0] ovl_seen
);
  localparam int unsigned LAST = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic ser_in;
    logic m_bit;
    logic s_bit;
    if (i == 0) begin : g_head
      assign ser_in = scan_in;
    end else begin : g_link
      assign ser_in = g_cell[i-1].s_bit;
    end
    lvl_scan_cell u_cell (
      .rst         (rst),
      .cap_clk     (cap_clk),
      .shift_clk_m (shift_clk_m),
      .shift_clk_s (shift_clk_s),
      .d_in        (par_in[i]),
      .s_in        (ser_in),
      .m_q         (m_bit),
      .s_q         (s_bit)
    );
    assign mst_q[i] = m_bit;
    assign slv_q[i] = s_bit;
  end

  assign scan_out = g_cell[LAST].s_bit;

  ovl_vec_t seen_w;

  lvl_scan_overlap u_ovl (
    .rst         (rst),
    .cap_clk     (cap_clk),
    .shift_clk_m (shift_clk_m),
    .shift_clk_s (shift_clk_s),
    .seen        (seen_w),
    .any         (ovl_any)
  );

  assign ovl_seen = seen_w;
endmodule

// File: rtl/lvl_scan_chain_chk.sv
module lvl_scan_chain_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             rst,
  input logic             cap_clk,
  input logic             shift_clk_m,
  input logic             shift_clk_s,
  input logic [WIDTH-1:0] par_in,
  input logic             scan_in,
  input logic [WIDTH-1:0] mst_q,
  input logic [WIDTH-1:0] slv_q,
  input logic             ovl_any,
  input logic [2:0]       ovl_seen
);
  AST_RESET_CLEAR: assert property (@(negedge rst) (mst_q == '0) && (slv_q == '0) && (ovl_seen == '0)); // R1

  AST_CAPTURE_MATCH: assert property (@(negedge cap_clk) disable iff (rst)
    !shift_clk_m |-> (mst_q == par_in)); // R2

  AST_SHIFT_LOAD: assert property (@(negedge shift_clk_m) disable iff (rst)
    (!cap_clk && !shift_clk_s) |-> (mst_q == {slv_q[WIDTH-2:0], scan_in})); // R3

  AST_SLAVE_COPY: assert property (@(negedge shift_clk_s) disable iff (rst)
    (!cap_clk && !shift_clk_m) |-> (slv_q == mst_q)); // R4

  AST_OVL_SLAVE: assert property (@(negedge shift_clk_s) disable iff (rst)
    (cap_clk || shift_clk_m) |-> ovl_any); // R7

  AST_OVL_CAPTURE: assert property (@(negedge cap_clk) disable iff (rst)
    shift_clk_m |-> (ovl_any && ovl_seen[0])); // R8

  always @(negedge ovl_any) begin
    AST_OVL_STICKY: assert (rst); // R7
  end
endmodule

bind lvl_scan_chain lvl_scan_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .rst         (rst),
  .cap_clk     (cap_clk),
  .shift_clk_m (shift_clk_m),
  .shift_clk_s (shift_clk_s),
  .par_in      (par_in),
  .scan_in     (scan_in),
  .mst_q       (mst_q),
  .slv_q       (slv_q),
  .ovl_any     (ovl_any),
  .ovl_seen    (ovl_seen)
);

// File: tb/lvl_scan_chain_test.sv
module lvl_scan_chain_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_clk = 1'b0;
  logic         shift_clk_m = 1'b0;
  logic         shift_clk_s = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] mst_q;
  logic [W-1:0] slv_q;
  logic         scan_out;
  logic         ovl_any;
  logic [2:0]   ovl_seen;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lvl_scan_chain #(.WIDTH(W)) uut (
    .rst(rst), .cap_clk(cap_clk), .shift_clk_m(shift_clk_m), .shift_clk_s(shift_clk_s),
    .par_in(par_in), .scan_in(scan_in), .mst_q(mst_q), .slv_q(slv_q),
    .scan_out(scan_out), .ovl_any(ovl_any), .ovl_seen(ovl_seen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk) rst = 1'b1;
    @(posedge clk) rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_c();
    @(posedge clk) cap_clk = 1'b1;
    @(posedge clk) cap_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_m();
    @(posedge clk) shift_clk_m = 1'b1;
    @(posedge clk) shift_clk_m = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_s();
    @(posedge clk) shift_clk_s = 1'b1;
    @(posedge clk) shift_clk_s = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mst", mst_q, 0);
    chk("R1 slv", slv_q, 0);
    chk("R1 ovl_any", ovl_any, 0);
    chk("R1 ovl_seen", ovl_seen, 0);
    chk("R1 scan_out", scan_out, 0);
  endtask

  task automatic t_reset_wins();
    @(posedge clk) rst = 1'b1;
    @(posedge clk) par_in = 8'hFF;
    @(posedge clk) cap_clk = 1'b1;
    @(negedge clk) chk("R10 mst under reset", mst_q, 0);
    @(posedge clk) cap_clk = 1'b0;
    @(posedge clk) rst = 1'b0;
    @(negedge clk) chk("R10 mst after reset", mst_q, 0);
  endtask

  task automatic t_capture();
    do_reset();
    @(posedge clk) par_in = 8'hA5;
    pulse_c();
    chk("R2 capture", mst_q, 8'hA5);
    chk("R4 slave holds", slv_q, 0);
    @(posedge clk) par_in = 8'h3C;
    @(negedge clk) chk("R2 data ignored", mst_q, 8'hA5);
    pulse_s();
    chk("R4 slave copy", slv_q, 8'hA5);
    chk("R5 scan_out", scan_out, 1);
  endtask

  task automatic t_shift_one();
    do_reset();
    @(posedge clk) par_in = 8'h96;
    pulse_c();
    pulse_s();
    @(posedge clk) scan_in = 1'b1;
    pulse_m();
    chk("R3 master load", mst_q, 8'h2D);
    chk("R4 slave holds on master pulse", slv_q, 8'h96);
    chk("R4 scan_out holds", scan_out, 1);
    pulse_s();
    chk("R6 one step", slv_q, 8'h2D);
  endtask

  task automatic t_shift_out();
    logic [W-1:0] p;
    p = 8'hC9;
    do_reset();
    @(posedge clk) par_in = p;
    pulse_c();
    pulse_s();
    @(posedge clk) scan_in = 1'b0;
    for (int k = 0; k < W; k++) begin
      chk("R5 serial out", scan_out, p[W-1-k]);
      pulse_m();
      pulse_s();
    end
    chk("R5 drained", slv_q, 0);
  endtask

  task automatic t_shift_in();
    logic [W-1:0] q;
    q = 8'h5B;
    do_reset();
    for (int k = 0; k < W; k++) begin
      @(posedge clk) scan_in = q[W-1-k];
      pulse_m();
      pulse_s();
    end
    chk("R6 serial in slv", slv_q, q);
    chk("R6 serial in mst", mst_q, q);
  endtask

  task automatic t_ovl_ca();
    do_reset();
    @(posedge clk) par_in = 8'h71;
    @(posedge clk) scan_in = 1'b1;
    @(posedge clk) shift_clk_m = 1'b1;
    @(posedge clk) cap_clk = 1'b1;
    @(negedge clk);
    chk("R9 capture priority", mst_q, 8'h71);
    chk("R7 flag set", ovl_any, 1);
    chk("R8 ca bit", ovl_seen, 3'b001);
    @(posedge clk) cap_clk = 1'b0;
    @(posedge clk) shift_clk_m = 1'b0;
    @(negedge clk);
    chk("R7 flag held", ovl_any, 1);
    pulse_c();
    pulse_s();
    chk("R7 held after legal pulses", ovl_any, 1);
    chk("R8 ca only", ovl_seen, 3'b001);
    do_reset();
    chk("R7 cleared by reset", ovl_any, 0);
  endtask

  task automatic t_ovl_cb_ab();
    do_reset();
    @(posedge clk) cap_clk = 1'b1;
    @(posedge clk) shift_clk_s = 1'b1;
    @(posedge clk) shift_clk_s = 1'b0;
    @(posedge clk) cap_clk = 1'b0;
    @(negedge clk);
    chk("R8 cb bit", ovl_seen, 3'b010);
    chk("R7 cb flag", ovl_any, 1);
    do_reset();
    @(posedge clk) shift_clk_m = 1'b1;
    @(posedge clk) shift_clk_s = 1'b1;
    @(posedge clk) shift_clk_s = 1'b0;
    @(posedge clk) shift_clk_m = 1'b0;
    @(negedge clk);
    chk("R8 ab bit", ovl_seen, 3'b100);
    @(posedge clk) cap_clk = 1'b1;
    @(posedge clk) shift_clk_s = 1'b1;
    @(posedge clk) shift_clk_s = 1'b0;
    @(posedge clk) cap_clk = 1'b0;
    @(negedge clk);
    chk("R8 bits accumulate", ovl_seen, 3'b110);
    do_reset();
  endtask

  logic done = 1'b0;

  initial begin
    @(negedge clk);
    chk("R1 power-up", {mst_q, slv_q}, 0);
    t_reset();
    t_reset_wins();
    t_capture();
    t_shift_one();
    t_shift_out();
    t_shift_in();
    t_ovl_ca();
    t_ovl_cb_ab();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule